// File: doc/BRIEF.md
# CAN Receive Acceptance Filter with Two Buffers

This block sits between a CAN frame receiver and a pair of receive buffers. When a complete frame has been received, its identifier and identifier type are presented with a one-cycle valid strobe. The block checks the frame against six programmable filters and two masks. It then raises a load strobe for at most one buffer, or it drops the frame. Buffer 0 owns filters 0 and 1 and mask 0. Buffer 1 owns filters 2 to 5 and mask 1. Buffer 0 is always evaluated first.

Each buffer has its own receive-mode field. The field can accept every frame, accept only one identifier type, or apply the filters to both types. Each filter is tied to either standard or extended frames. When a buffer is loaded, the number of the filter that matched is recorded for that buffer.

A loaded buffer raises its receive flag. It accepts no further frame until the flag is cleared from outside, so a pending message is never overwritten. An optional rollover lets a frame meant for a full buffer 0 go into an empty buffer 1. A frame that is accepted but has nowhere to go produces a one-cycle overflow pulse.

Top module: `can_accept_filter`

## Requirements
- R1: After reset, load0_o, load1_o, ovf_o and rx_flag_o are 0, and filhit0_o and filhit1_o are 0.
- R2: Filters 0 and 1 use mask 0 and serve buffer 0. Filters 2 to 5 use mask 1 and serve buffer 1. All outputs are registered, so the result of a frame presented with frm_valid_i in cycle n appears in cycle n+1. load0_o, load1_o and ovf_o are one-cycle pulses.
- R3: Buffer 0 is evaluated first. If buffer 0 accepts the frame, buffer 1 is never loaded from buffer 1's own filters, even when they also match. At most one of load0_o, load1_o and ovf_o is high in any cycle.
- R4: filt_ext_i[k] set makes filter k match only extended frames (frm_ext_i=1). When it is clear, filter k matches only standard frames.
- R5: A mask bit of 1 requires the frame identifier bit to equal the filter bit. A mask bit of 0 makes that bit don't-care.
- R6: Identifiers are 29 bits wide. A standard identifier occupies bits [28:18]. Standard frames compare only bits [28:18]. Extended frames compare all 29 bits.
- R7: The mode field for each buffer works as follows. 2'b11 accepts every frame without filtering. 2'b10 accepts only extended frames that match a filter. 2'b01 accepts only standard frames that match a filter. 2'b00 accepts frames of either type that match a filter.
- R8: On a load, filhitN_o takes the number of the lowest-numbered matching filter in the accepting group. In accept-all mode with no matching filter, it takes the group's first filter number (0 or 2). The value holds until that buffer is loaded again.
- R9: A load sets the buffer's rx_flag_o bit. The bit stays set until clrN_i is pulsed. While the bit is set and not being cleared, the buffer is never loaded. A clear in the same cycle as a frame frees the buffer for that frame.
- R10: With rollover_en_i high, a frame accepted by buffer 0 while buffer 0 is full and buffer 1 is free is loaded into buffer 1. filhit1_o then reports the buffer-0 filter number.
- R11: A frame whose accepting buffer is full, with no rollover available, raises ovf_o for one cycle and changes no flag or filter-hit output. A frame that no buffer accepts is dropped silently, with no pulse and no change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mask0_i | input | 29 | Mask for buffer 0 |
| mask1_i | input | 29 | Mask for buffer 1 |
| filt_id_i | input | 174 | Six 29-bit filter values; filter k sits at [29k+28:29k] |
| filt_ext_i | input | 6 | Identifier type per filter (1 = extended) |
| mode0_i | input | 2 | Receive mode for buffer 0 |
| mode1_i | input | 2 | Receive mode for buffer 1 |
| rollover_en_i | input | 1 | Allows rollover from buffer 0 into buffer 1 |
| frm_valid_i | input | 1 | One-cycle strobe: a complete frame is present |
| frm_id_i | input | 29 | Frame identifier (standard part in [28:18]) |
| frm_ext_i | input | 1 | Frame carries an extended identifier |
| clr0_i | input | 1 | Clears the buffer 0 receive flag |
| clr1_i | input | 1 | Clears the buffer 1 receive flag |
| load0_o | output | 1 | Load strobe for buffer 0 |
| load1_o | output | 1 | Load strobe for buffer 1 |
| filhit0_o | output | 3 | Filter number of the last frame loaded into buffer 0 |
| filhit1_o | output | 3 | Filter number of the last frame loaded into buffer 1 |
| rx_flag_o | output | 2 | Receive flags, one bit per buffer |
| ovf_o | output | 1 | One-cycle pulse: an accepted frame was lost |

## Verification
A wrong lock flag shows up at the ports one cycle after the next frame. A flag stuck at 1 turns an expected load into an overflow pulse. A flag stuck at 0 lets a second load through, and that load overwrites the filter-hit code. A wrong filter-hit register, or a broken evaluation order, shows up as a wrong code or a wrong buffer strobe in the cycle after the frame. For that reason the bench compares every strobe, both flags and both hit codes after each frame. This catches a fault in the frame where it first matters, not several frames later.

// File: rtl/can_acc_pkg.sv
package can_acc_pkg;
  localparam int unsigned ID_W     = 29;
  localparam int unsigned STD_W    = 11;
  localparam int unsigned NUM_FILT = 6;
  localparam int unsigned FILT_B0  = 2;
  localparam int unsigned HIT_W    = $clog2(NUM_FILT);

  typedef enum logic [1:0] {
    RXM_FILT = 2'b00,
    RXM_STD  = 2'b01,
    RXM_EXT  = 2'b10,
    RXM_ALL  = 2'b11
  } rx_mode_e;
endpackage

// File: rtl/can_id_match.sv
module can_id_match #(
  parameter int unsigned ID_W     = 29,
  parameter int unsigned STD_W    = 11,
  parameter int unsigned NUM_FILT = 6,
  parameter int unsigned FILT_B0  = 2
) (
  input  logic [ID_W-1:0]          id_i,
  input  logic                     ext_i,
  input  logic [ID_W-1:0]          mask0_i,
  input  logic [ID_W-1:0]          mask1_i,
  input  logic [NUM_FILT*ID_W-1:0] filt_id_i,
  input  logic [NUM_FILT-1:0]      filt_ext_i,
  output logic [NUM_FILT-1:0]      hit_o
);
  localparam int unsigned EXT_ONLY_W = ID_W - STD_W;
  localparam logic [ID_W-1:0] STD_SPAN = {{STD_W{1'b1}}, {EXT_ONLY_W{1'b0}}};

  logic [ID_W-1:0] span;
  assign span = ext_i ? {ID_W{1'b1}} : STD_SPAN;

  for (genvar g = 0; g < NUM_FILT; g++) begin : g_filt
    logic [ID_W-1:0] msk;
    logic [ID_W-1:0] diff;
    if (g < FILT_B0) begin : g_b0
      assign msk = mask0_i;
    end else begin : g_b1
      assign msk = mask1_i;
    end
    assign diff     = (id_i ^ filt_id_i[g*ID_W +: ID_W]) & msk & span;
    assign hit_o[g] = (filt_ext_i[g] == ext_i) && (diff == '0);
  end
endmodule

// File: rtl/can_buf_sel.sv
module can_buf_sel
  import can_acc_pkg::*;
#(
  parameter int unsigned NUM_FILT = 6,
  parameter int unsigned FILT_B0  = 2,
  parameter int unsigned HIT_W    = 3
) (
  input  logic [NUM_FILT-1:0] hit_i,
  input  logic                ext_i,
  input  logic [1:0]          mode0_i,
  input  logic [1:0]          mode1_i,
  output logic                acc0_o,
  output logic                acc1_o,
  output logic [HIT_W-1:0]    code0_o,
  output logic [HIT_W-1:0]    code1_o
);
  logic any0, any1;
  logic [HIT_W-1:0] pe0, pe1;

  // lowest-numbered hit per group wins
  always_comb begin
    any0 = 1'b0;
    any1 = 1'b0;
    pe0  = '0;
    pe1  = HIT_W'(FILT_B0);
    for (int i = NUM_FILT - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        if (i < int'(FILT_B0)) begin
          any0 = 1'b1;
          pe0  = HIT_W'(i);
        end else begin
          any1 = 1'b1;
          pe1  = HIT_W'(i);
        end
      end
    end
  end

  function automatic logic mode_ok(input logic [1:0] m, input logic ext, input logic any);
    unique case (rx_mode_e'(m))
      RXM_ALL: mode_ok = 1'b1;
      RXM_EXT: mode_ok = ext & any;
      RXM_STD: mode_ok = ~ext & any;
      default: mode_ok = any;
    endcase
  endfunction

  assign acc0_o  = mode_ok(mode0_i, ext_i, any0);
  assign acc1_o  = mode_ok(mode1_i, ext_i, any1);
  assign code0_o = pe0;
  assign code1_o = pe1;
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
  import can_acc_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [ID_W-1:0]          mask0_i,
  input  logic [ID_W-1:0]          mask1_i,
  input  logic [NUM_FILT*ID_W-1:0] filt_id_i,
  input  logic [NUM_FILT-1:0]      filt_ext_i,
  input  logic [1:0]               mode0_i,
  input  logic [1:0]               mode1_i,
  input  logic                     rollover_en_i,
  input  logic                     frm_valid_i,
  input  logic [ID_W-1:0]          frm_id_i,
  input  logic                     frm_ext_i,
  input  logic                     clr0_i,
  input  logic                     clr1_i,
  output logic                     load0_o,
  output logic                     load1_o,
  output logic [HIT_W-1:0]         filhit0_o,
  output logic [HIT_W-1:0]         filhit1_o,
  output logic [1:0]               rx_flag_o,
  output logic                     ovf_o
);
  logic [NUM_FILT-1:0] hit;
  logic acc0, acc1;
  logic [HIT_W-1:0] code0, code1;

  can_id_match #(
    .ID_W(ID_W), .STD_W(STD_W), .NUM_FILT(NUM_FILT), .FILT_B0(FILT_B0)
  ) u_match (
    .id_i(frm_id_i), .ext_i(frm_ext_i), .mask0_i(mask0_i), .mask1_i(mask1_i),
    .filt_id_i(filt_id_i), .filt_ext_i(filt_ext_i), .hit_o(hit)
  );

  can_buf_sel #(
    .NUM_FILT(NUM_FILT), .FILT_B0(FILT_B0), .HIT_W(HIT_W)
  ) u_sel (
    .hit_i(hit), .ext_i(frm_ext_i), .mode0_i(mode0_i), .mode1_i(mode1_i),
    .acc0_o(acc0), .acc1_o(acc1), .code0_o(code0), .code1_o(code1)
  );

  logic flag0_q, flag1_q, ld0_q, ld1_q, ovf_q;
  logic [HIT_W-1:0] fh0_q, fh1_q;
  logic free0, free1, ld0, ld1, roll, ovf;

  // clear in the same cycle frees the buffer for that frame
  assign free0 = ~flag0_q | clr0_i;
  assign free1 = ~flag1_q | clr1_i;

  always_comb begin
    ld0  = frm_valid_i & acc0 & free0;
    roll = frm_valid_i & acc0 & ~free0 & rollover_en_i & free1;
    ld1  = roll | (frm_valid_i & ~acc0 & acc1 & free1);
    ovf  = frm_valid_i & ((acc0 & ~free0 & ~(rollover_en_i & free1)) |
                          (~acc0 & acc1 & ~free1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag0_q <= 1'b0;
      flag1_q <= 1'b0;
      ld0_q   <= 1'b0;
      ld1_q   <= 1'b0;
      ovf_q   <= 1'b0;
      fh0_q   <= '0;
      fh1_q   <= '0;
    end else begin
      flag0_q <= (flag0_q & ~clr0_i) | ld0;
      flag1_q <= (flag1_q & ~clr1_i) | ld1;
      ld0_q   <= ld0;
      ld1_q   <= ld1;
      ovf_q   <= ovf;
      if (ld0) fh0_q <= code0;
      if (ld1) fh1_q <= roll ? code0 : code1;
    end
  end

  assign load0_o   = ld0_q;
  assign load1_o   = ld1_q;
  assign ovf_o     = ovf_q;
  assign rx_flag_o = {flag1_q, flag0_q};
  assign filhit0_o = fh0_q;
  assign filhit1_o = fh1_q;
endmodule

// File: rtl/can_accept_filter_chk.sv
module can_accept_filter_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       frm_valid_i,
  input logic       clr0_i,
  input logic       clr1_i,
  input logic       load0_o,
  input logic       load1_o,
  input logic       ovf_o,
  input logic [1:0] rx_flag_o,
  input logic [2:0] filhit0_o,
  input logic [2:0] filhit1_o
);
  // R3
  one_outcome_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({load0_o, load1_o, ovf_o}));

  // R2
  outcome_needs_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load0_o || load1_o || ovf_o) |-> $past(frm_valid_i));

  // R9
  no_overwrite0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load0_o |-> !$past(rx_flag_o[0] && !clr0_i));

  // R9
  no_overwrite1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load1_o |-> !$past(rx_flag_o[1] && !clr1_i));

  // R9
  flag_hold0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_flag_o[0] && !clr0_i) |=> rx_flag_o[0]);

  // R9
  load_sets_flag1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load1_o |-> rx_flag_o[1]);

  // R8
  hit0_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load0_o |-> $stable(filhit0_o));

  // R8
  hit1_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load1_o |-> $stable(filhit1_o));
endmodule

bind can_accept_filter can_accept_filter_chk u_chk (.*);

// File: tb/can_accept_filter_tb.sv
`timescale 1ns/1ps
module can_accept_filter_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [28:0] m0, m1;
  logic [28:0] fid [6];
  logic [5:0]  fext;
  logic [1:0]  md0, md1;
  logic        roll_en;
  logic        fv, fe, c0, c1;
  logic [28:0] fidn;
  logic [6*29-1:0] filt_flat;
  logic ld0, ld1, ovf;
  logic [2:0] fh0, fh1;
  logic [1:0] flg;

  always_comb for (int i = 0; i < 6; i++) filt_flat[i*29 +: 29] = fid[i];

  can_accept_filter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mask0_i(m0), .mask1_i(m1),
    .filt_id_i(filt_flat), .filt_ext_i(fext), .mode0_i(md0), .mode1_i(md1),
    .rollover_en_i(roll_en), .frm_valid_i(fv), .frm_id_i(fidn), .frm_ext_i(fe),
    .clr0_i(c0), .clr1_i(c1), .load0_o(ld0), .load1_o(ld1),
    .filhit0_o(fh0), .filhit1_o(fh1), .rx_flag_o(flg), .ovf_o(ovf)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  typedef struct {
    logic l0, l1, ov;
    logic [2:0] h0, h1;
    logic [1:0] fl;
    string tag;
  } exp_t;
  exp_t q[$];
  event chk_ev;

  // bench model state
  logic mf0 = 0, mf1 = 0;
  logic [2:0] mh0 = 0, mh1 = 0;

  function automatic void chk(bit ok, string tag, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
    end
  endfunction

  function automatic logic [28:0] sid(input logic [10:0] s);
    return {s, 18'h0};
  endfunction

  task automatic send(input logic [28:0] id, input logic ext,
                      input logic k0, input logic k1, input string tag);
    logic [28:0] span;
    logic m [6];
    logic any0, any1, a0, a1, fr0, fr1;
    logic [2:0] p0, p1;
    exp_t e;
    span = ext ? 29'h1FFFFFFF : {11'h7FF, 18'h0};
    any0 = 0; any1 = 0; p0 = 3'd0; p1 = 3'd2;
    for (int k = 5; k >= 0; k--) begin
      logic [28:0] mk;
      mk = (k < 2) ? m0 : m1;
      m[k] = (fext[k] == ext) && (((id ^ fid[k]) & mk & span) == 29'h0);
      if (m[k]) begin
        if (k < 2) begin any0 = 1; p0 = 3'(k); end
        else begin any1 = 1; p1 = 3'(k); end
      end
    end
    a0 = (md0 == 2'b11) ? 1'b1 : (md0 == 2'b10) ? (ext & any0) :
         (md0 == 2'b01) ? (!ext & any0) : any0;
    a1 = (md1 == 2'b11) ? 1'b1 : (md1 == 2'b10) ? (ext & any1) :
         (md1 == 2'b01) ? (!ext & any1) : any1;
    if (k0) mf0 = 0;
    if (k1) mf1 = 0;
    fr0 = !mf0; fr1 = !mf1;
    e.l0 = 0; e.l1 = 0; e.ov = 0;
    if (a0) begin
      if (fr0) begin e.l0 = 1; mf0 = 1; mh0 = p0; end
      else if (roll_en && fr1) begin e.l1 = 1; mf1 = 1; mh1 = p0; end
      else e.ov = 1;
    end else if (a1) begin
      if (fr1) begin e.l1 = 1; mf1 = 1; mh1 = p1; end
      else e.ov = 1;
    end
    e.h0 = mh0; e.h1 = mh1; e.fl = {mf1, mf0}; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    fv = 1; fidn = id; fe = ext; c0 = k0; c1 = k1;
    @(negedge clk);
    fv = 0; c0 = 0; c1 = 0;
    #1 -> chk_ev;
  endtask

  task automatic clr_only(input logic k0, input logic k1, input string tag);
    @(negedge clk);
    c0 = k0; c1 = k1;
    if (k0) mf0 = 0;
    if (k1) mf1 = 0;
    @(negedge clk);
    c0 = 0; c1 = 0;
    chk(flg == {mf1, mf0} && !ld0 && !ld1 && !ovf, {tag, " clear"},
        int'(flg), int'({mf1, mf0}));
  endtask

  // monitor: pops expected item once the result is visible
  initial begin
    forever begin
      exp_t e;
      @(chk_ev);
      e = q.pop_front();
      chk(ld0 == e.l0, {e.tag, " load0"}, int'(ld0), int'(e.l0));
      chk(ld1 == e.l1, {e.tag, " load1"}, int'(ld1), int'(e.l1));
      chk(ovf == e.ov, {e.tag, " ovf"}, int'(ovf), int'(e.ov));
      chk(flg == e.fl, {e.tag, " flags"}, int'(flg), int'(e.fl));
      chk(fh0 == e.h0, {e.tag, " filhit0"}, int'(fh0), int'(e.h0));
      chk(fh1 == e.h1, {e.tag, " filhit1"}, int'(fh1), int'(e.h1));
      @(negedge clk);
      chk(!ld0 && !ld1 && !ovf, {e.tag, " R2 pulse width"},
          int'({ld0, ld1, ovf}), 0);
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    fv = 0; fe = 0; c0 = 0; c1 = 0; fidn = '0; roll_en = 0;
    md0 = 2'b00; md1 = 2'b00;
    // buffer 0 shut for standard traffic: extended-only filters, full mask
    m0 = 29'h1FFFFFFF; fid[0] = 29'h1FFFFFFF; fid[1] = 29'h1FFFFFFF;
    m1 = {11'h7FF, 18'h0};
    fid[2] = sid(11'h150); fid[3] = sid(11'h151);
    fid[4] = sid(11'h152); fid[5] = sid(11'h153);
    fext = 6'b000011;
    repeat (3) @(negedge clk);
    // R1
    chk(flg == 2'b00 && !ld0 && !ld1 && !ovf && fh0 == 0 && fh1 == 0,
        "R1 reset state", int'({flg, ld0, ld1, ovf}), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    send(sid(11'h152), 0, 0, 0, "R2 buf1 filter4");
    send(sid(11'h153), 0, 0, 0, "R11 buf1 locked");
    send(sid(11'h153), 0, 0, 1, "R9 clear same cycle");
    clr_only(0, 1, "R9");
    send(sid(11'h1FF), 0, 0, 0, "R11 no match dropped");
    send(sid(11'h152) | 29'h0002A5, 0, 0, 0, "R6 std ignores low bits");
    clr_only(0, 1, "R9");

    // buffer 0 gets a standard filter equal to filter 4
    m0 = {11'h7FF, 18'h0}; fid[0] = sid(11'h152); fext[0] = 0;
    send(sid(11'h152), 0, 0, 0, "R3 buf0 first");
    send(sid(11'h152), 0, 0, 0, "R3 buf0 full no rollover");
    roll_en = 1;
    send(sid(11'h152), 0, 0, 0, "R10 rollover");
    send(sid(11'h152), 0, 0, 0, "R11 both full");
    clr_only(1, 1, "R9");
    roll_en = 0;

    // extended filter 1
    m0 = 29'h1FFFFFFF; fid[1] = 29'h0ABCDE1; fext[1] = 1;
    send(29'h0ABCDE1, 1, 0, 0, "R4 ext filter1");
    send(29'h0ABCDE0, 1, 1, 0, "R6 ext all bits");
    send(29'h0ABCDE1, 0, 0, 0, "R4 std frame vs ext filter");
    m1 = {11'h7FC, 18'h0};
    send(sid(11'h151), 0, 0, 0, "R5 mask dont care");

    md0 = 2'b11;
    send(sid(11'h3AA), 0, 0, 0, "R7 accept all");
    send(29'h0ABCDE1, 1, 1, 0, "R7 accept all hit code");
    clr_only(1, 0, "R9");
    md0 = 2'b01;
    send(29'h0ABCDE1, 1, 0, 0, "R7 std only rejects ext");
    md0 = 2'b10;
    send(sid(11'h152), 0, 0, 1, "R7 ext only passes to buf1");
    md0 = 2'b00;
    send(sid(11'h152), 0, 0, 0, "R3 filter mode both");

    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule